// File: doc/BRIEF.md
# Paired-Page Associative Translation Buffer

This block is a fully associative address translation cache. Each of its entries maps a pair of adjacent virtual pages (an even page and an odd page) to two independent physical frames. The page size is chosen per entry through a page-size mask. An entry matches a lookup in either of two cases: it carries the same address-space identifier as the lookup, or it is marked global.

A lookup presents a virtual address, the current address-space identifier and a write flag. One clock later the block answers with one of two results. The first is a physical address together with a read-only or read/write indication. The second is a fault: an exception code, a flag telling a refill miss apart from a fault on an entry that matched, and the faulting page-pair number and identifier for the exception context. Entries are loaded through a plain indexed write port. Replacement choice, probing and address-segment decoding are left to the surrounding logic.

Top module: `paired_tlb`

## Requirements
- R1: The 27-bit page mask picks the page shift: 0x7FF→10, 0x1FFF→12, 0x7FFF→14, 0x1FFFF→16, 0x7FFFF→18, 0x1FFFFF→20, 0x7FFFFF→22, 0x1FFFFFF→24, 0x7FFFFFF→26. Any other value gives shift 12.
- R2: An entry matches when the virtual address equals the entry tag in every bit at or above shift+1, and either the entry identifier equals the lookup identifier or the entry global bit is set.
- R3: Virtual address bit [shift] selects the odd-page low word (1) or the even-page low word (0).
- R4: In a low word, bits [29:6] are the frame number, bit 1 is valid and bit 2 is dirty. The physical address is frame<<12 ORed with the virtual address bits below the shift.
- R5: A match on a valid, dirty page succeeds. It reports rs_rw=1, rs_fault=0 and code 0.
- R6: A match on a valid, clean page succeeds for a read with rs_rw=0. For a write it faults with code 1 and refill 0.
- R7: A match on an invalid page faults with refill 0. The code is 2 for a read and 3 for a write.
- R8: With no matching entry the block faults with refill 1. The code is 2 for a read and 3 for a write.
- R9: When several entries match, the one with the lowest index decides.
- R10: The response appears on the clock after the request. A table write in the same cycle as a lookup is not seen by that lookup, but is seen by the next one.
- R11: On a fault, rs_bad_vpn2 holds virtual address bits [31:13], rs_bad_asid holds the lookup identifier and rs_paddr is zero. Without a fault, both context outputs are zero.
- R12: Reset clears rs_valid and sets every entry to tag 0, identifier 0, not global, shift 12, with both pages invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load an entry |
| wr_idx | input | 6 | Entry index to load |
| wr_pagemask | input | 27 | Page-size mask of the new entry |
| wr_vtag | input | 32 | Virtual tag; bits below shift+1 are ignored |
| wr_asid | input | 8 | Address-space identifier of the new entry |
| wr_global | input | 1 | Match any identifier |
| wr_lo0 | input | 32 | Even-page low word |
| wr_lo1 | input | 32 | Odd-page low word |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address |
| lk_asid | input | 8 | Current address-space identifier |
| lk_write | input | 1 | Access is a store |
| rs_valid | output | 1 | Response valid |
| rs_fault | output | 1 | Translation failed |
| rs_refill | output | 1 | Failure was a miss |
| rs_code | output | 5 | Exception code (0 none, 1 modified, 2 load, 3 store) |
| rs_paddr | output | 36 | Physical address |
| rs_rw | output | 1 | Page is writable |
| rs_bad_vpn2 | output | 19 | Faulting page-pair number |
| rs_bad_asid | output | 8 | Faulting identifier |

## Verification
A table write and a lookup can land in the same cycle. This includes a write that rewrites the very entry being looked up, for example one that turns a clean page dirty. The bench drives this collision on purpose in a directed case and also at random points in the random phase. Its model resolves each such lookup against the table contents from before the write, and the lookup that follows is expected to see the new entry.

// File: rtl/paired_tlb.sv
module paired_tlb #(
  parameter int ENTRIES = 48,
  parameter int VA_W    = 32,
  parameter int PA_W    = 36,
  parameter int ASID_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [$clog2(ENTRIES)-1:0] wr_idx,
  input  logic [26:0]             wr_pagemask,
  input  logic [VA_W-1:0]         wr_vtag,
  input  logic [ASID_W-1:0]       wr_asid,
  input  logic                    wr_global,
  input  logic [31:0]             wr_lo0,
  input  logic [31:0]             wr_lo1,
  input  logic                    lk_valid,
  input  logic [VA_W-1:0]         lk_vaddr,
  input  logic [ASID_W-1:0]       lk_asid,
  input  logic                    lk_write,
  output logic                    rs_valid,
  output logic                    rs_fault,
  output logic                    rs_refill,
  output logic [4:0]              rs_code,
  output logic [PA_W-1:0]         rs_paddr,
  output logic                    rs_rw,
  output logic [VA_W-14:0]        rs_bad_vpn2,
  output logic [ASID_W-1:0]       rs_bad_asid
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int PFN_W = PA_W - 12;
  localparam logic [4:0] CODE_MOD  = 5'd1;
  localparam logic [4:0] CODE_LOAD = 5'd2;
  localparam logic [4:0] CODE_STOR = 5'd3;

  function automatic logic [4:0] mask_to_shift(input logic [26:0] m);
    case (m)
      27'h00007FF: return 5'd10;
      27'h0001FFF: return 5'd12;
      27'h0007FFF: return 5'd14;
      27'h001FFFF: return 5'd16;
      27'h007FFFF: return 5'd18;
      27'h01FFFFF: return 5'd20;
      27'h07FFFFF: return 5'd22;
      27'h1FFFFFF: return 5'd24;
      27'h7FFFFFF: return 5'd26;
      default:     return 5'd12;
    endcase
  endfunction

  logic [VA_W-1:0]   e_tag  [ENTRIES];
  logic [ASID_W-1:0] e_asid [ENTRIES];
  logic              e_glb  [ENTRIES];
  logic [4:0]        e_sh   [ENTRIES];
  logic [31:0]       e_lo0  [ENTRIES];
  logic [31:0]       e_lo1  [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        e_tag[i]  <= '0;
        e_asid[i] <= '0;
        e_glb[i]  <= 1'b0;
        e_sh[i]   <= 5'd12;
        e_lo0[i]  <= '0;
        e_lo1[i]  <= '0;
      end
    end else if (wr_en && (32'(wr_idx) < ENTRIES)) begin
      e_tag[wr_idx]  <= wr_vtag;
      e_asid[wr_idx] <= wr_asid;
      e_glb[wr_idx]  <= wr_global;
      e_sh[wr_idx]   <= mask_to_shift(wr_pagemask);
      e_lo0[wr_idx]  <= wr_lo0;
      e_lo1[wr_idx]  <= wr_lo1;
    end
  end

  logic             hit;
  logic [IDX_W-1:0] hsel;
  logic [VA_W-1:0]  keep;

  always_comb begin
    hit  = 1'b0;
    hsel = '0;
    keep = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      keep = {VA_W{1'b1}} << (e_sh[i] + 5'd1);
      if ((((lk_vaddr ^ e_tag[i]) & keep) == '0) &&
          ((e_asid[i] == lk_asid) || e_glb[i])) begin
        hit  = 1'b1;
        hsel = IDX_W'(i);
      end
    end
  end

  logic [4:0]      sel_sh;
  logic            odd;
  logic [31:0]     sel_lo;
  logic [PA_W-1:0] off_mask;
  logic [PA_W-1:0] paddr_c;

  assign sel_sh   = e_sh[hsel];
  assign odd      = |((lk_vaddr >> sel_sh) & VA_W'(1));
  assign sel_lo   = odd ? e_lo1[hsel] : e_lo0[hsel];
  assign off_mask = ~({PA_W{1'b1}} << sel_sh);
  assign paddr_c  = {sel_lo[PFN_W+5:6], 12'h000} | (PA_W'(lk_vaddr) & off_mask);

  logic       fault_c, refill_c, rw_c;
  logic [4:0] code_c;
  logic [4:0] miss_code;

  assign miss_code = lk_write ? CODE_STOR : CODE_LOAD;

  always_comb begin
    fault_c  = 1'b0;
    refill_c = 1'b0;
    rw_c     = 1'b0;
    code_c   = 5'd0;
    if (!hit) begin
      fault_c  = 1'b1;
      refill_c = 1'b1;
      code_c   = miss_code;
    end else if (!sel_lo[1]) begin
      fault_c = 1'b1;
      code_c  = miss_code;
    end else if (!sel_lo[2] && lk_write) begin
      fault_c = 1'b1;
      code_c  = CODE_MOD;
    end else begin
      rw_c = sel_lo[2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_valid    <= 1'b0;
      rs_fault    <= 1'b0;
      rs_refill   <= 1'b0;
      rs_code     <= '0;
      rs_paddr    <= '0;
      rs_rw       <= 1'b0;
      rs_bad_vpn2 <= '0;
      rs_bad_asid <= '0;
    end else begin
      rs_valid    <= lk_valid;
      rs_fault    <= lk_valid && fault_c;
      rs_refill   <= lk_valid && refill_c;
      rs_code     <= lk_valid ? code_c : 5'd0;
      rs_paddr    <= (lk_valid && !fault_c) ? paddr_c : '0;
      rs_rw       <= lk_valid && !fault_c && rw_c;
      rs_bad_vpn2 <= (lk_valid && fault_c) ? lk_vaddr[VA_W-1:13] : '0;
      rs_bad_asid <= (lk_valid && fault_c) ? lk_asid : '0;
    end
  end
endmodule

module paired_tlb_props #(
  parameter int ENTRIES = 48,
  parameter int VA_W    = 32,
  parameter int PA_W    = 36,
  parameter int ASID_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic [ASID_W-1:0] lk_asid,
  input logic              lk_write,
  input logic              rs_valid,
  input logic              rs_fault,
  input logic              rs_refill,
  input logic [4:0]        rs_code,
  input logic [PA_W-1:0]   rs_paddr,
  input logic              rs_rw,
  input logic [ASID_W-1:0] rs_bad_asid
);
  p_resp_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rs_valid);
  p_no_resp_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rs_valid);
  p_refill_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rs_refill |-> rs_fault && (rs_code == ($past(lk_write) ? 5'd3 : 5'd2)));
  p_mod_on_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_code == 5'd1) |-> rs_fault && !rs_refill && $past(lk_write));
  p_code_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rs_fault |-> (rs_code == 5'd1 || rs_code == 5'd2 || rs_code == 5'd3));
  p_clean_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_fault |-> rs_code == 5'd0);
  p_rw_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rs_rw |-> rs_valid && !rs_fault);
  p_fault_ctx_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rs_fault |-> rs_bad_asid == $past(lk_asid) && rs_paddr == '0);
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_valid |-> !rs_fault && !rs_rw && !rs_refill);
endmodule

bind paired_tlb paired_tlb_props #(
  .ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W)
) u_props (.*);

// File: tb/paired_tlb_bench.sv
`timescale 1ns/1ps
module paired_tlb_bench;
  localparam int N = 48;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [26:0] wr_pagemask = '0;
  logic [31:0] wr_vtag = '0;
  logic [7:0]  wr_asid = '0;
  logic        wr_global = 1'b0;
  logic [31:0] wr_lo0 = '0, wr_lo1 = '0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [7:0]  lk_asid = '0;
  logic        lk_write = 1'b0;
  logic        rs_valid, rs_fault, rs_refill, rs_rw;
  logic [4:0]  rs_code;
  logic [35:0] rs_paddr;
  logic [18:0] rs_bad_vpn2;
  logic [7:0]  rs_bad_asid;

  always #2 clk = ~clk;

  paired_tlb u_paired_tlb (.*);

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [31:0] m_tag [N];
  logic [7:0]  m_asid[N];
  logic        m_glb [N];
  int          m_sh  [N];
  logic [31:0] m_lo0 [N];
  logic [31:0] m_lo1 [N];

  logic        x_fault, x_refill, x_rw;
  logic [4:0]  x_code;
  logic [35:0] x_pa;
  logic [18:0] x_vpn;
  logic [7:0]  x_asid;

  function automatic int shift_of(input logic [26:0] m);
    for (int k = 0; k < 9; k++)
      if (m == 27'((64'd1 << (11 + 2 * k)) - 1)) return 10 + 2 * k;
    return 12;
  endfunction

  function automatic logic [26:0] pat(input int k);
    return (k < 9) ? 27'((64'd1 << (11 + 2 * k)) - 1) : 27'h0000123;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_tag[i] = '0; m_asid[i] = '0; m_glb[i] = 1'b0;
      m_sh[i] = 12; m_lo0[i] = '0; m_lo1[i] = '0;
    end
  endtask

  task automatic model_write(input int i, input logic [26:0] m, input logic [31:0] t,
                             input logic [7:0] a, input logic g,
                             input logic [31:0] l0, input logic [31:0] l1);
    m_tag[i] = t; m_asid[i] = a; m_glb[i] = g;
    m_sh[i] = shift_of(m); m_lo0[i] = l0; m_lo1[i] = l1;
  endtask

  task automatic predict(input logic [31:0] va, input logic [7:0] a, input logic w);
    int hi = -1;
    logic [31:0] lo;
    logic [31:0] keep;
    for (int i = 0; i < N; i++) begin
      keep = 32'hFFFF_FFFF << (m_sh[i] + 1);
      if (hi < 0 && ((va & keep) == (m_tag[i] & keep)) && (m_asid[i] == a || m_glb[i]))
        hi = i;
    end
    x_fault = 1'b0; x_refill = 1'b0; x_rw = 1'b0; x_code = 5'd0; x_pa = '0;
    if (hi < 0) begin
      x_fault = 1'b1; x_refill = 1'b1; x_code = w ? 5'd3 : 5'd2;
    end else begin
      lo = va[m_sh[hi]] ? m_lo1[hi] : m_lo0[hi];
      if (!lo[1]) begin
        x_fault = 1'b1; x_code = w ? 5'd3 : 5'd2;
      end else if (!lo[2] && w) begin
        x_fault = 1'b1; x_code = 5'd1;
      end else begin
        x_rw = lo[2];
        x_pa = {lo[29:6], 12'h000} | (36'(va) & ~(36'hF_FFFF_FFFF << m_sh[hi]));
      end
    end
    x_vpn  = x_fault ? va[31:13] : '0;
    x_asid = x_fault ? a : '0;
  endtask

  task automatic compare(input string req);
    checks++;
    if (rs_valid !== 1'b1 || rs_fault !== x_fault || rs_refill !== x_refill ||
        rs_code !== x_code || rs_paddr !== x_pa || rs_rw !== x_rw ||
        rs_bad_vpn2 !== x_vpn || rs_bad_asid !== x_asid) begin
      errors++;
      $display("FAIL %s: got v%0b f%0b r%0b c%0d pa%h rw%0b vpn%h as%h exp v1 f%0b r%0b c%0d pa%h rw%0b vpn%h as%h",
               req, rs_valid, rs_fault, rs_refill, rs_code, rs_paddr, rs_rw, rs_bad_vpn2, rs_bad_asid,
               x_fault, x_refill, x_code, x_pa, x_rw, x_vpn, x_asid);
    end
  endtask

  task automatic put(input int i, input logic [26:0] m, input logic [31:0] t,
                     input logic [7:0] a, input logic g,
                     input logic [31:0] l0, input logic [31:0] l1);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 6'(i); wr_pagemask = m; wr_vtag = t;
    wr_asid = a; wr_global = g; wr_lo0 = l0; wr_lo1 = l1;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(i, m, t, a, g, l0, l1);
  endtask

  task automatic look(input logic [31:0] va, input logic [7:0] a, input logic w, input string req);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va; lk_asid = a; lk_write = w;
    predict(va, a, w);
    @(negedge clk);
    lk_valid = 1'b0;
    compare(req);
  endtask

  task automatic look_and_put(input logic [31:0] va, input logic [7:0] a, input logic w,
                              input int i, input logic [26:0] m, input logic [31:0] t,
                              input logic [7:0] ea, input logic g,
                              input logic [31:0] l0, input logic [31:0] l1);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va; lk_asid = a; lk_write = w;
    wr_en = 1'b1; wr_idx = 6'(i); wr_pagemask = m; wr_vtag = t;
    wr_asid = ea; wr_global = g; wr_lo0 = l0; wr_lo1 = l1;
    predict(va, a, w);
    @(negedge clk);
    lk_valid = 1'b0; wr_en = 1'b0;
    compare("R10 collision");
    model_write(i, m, t, ea, g, l0, l1);
  endtask

  function automatic logic [31:0] lo_word(input logic [23:0] pfn, input logic v, input logic d);
    return {2'b00, pfn, 3'b000, d, v, 1'b0};
  endfunction

  initial begin
    int unsigned r;
    r = $urandom(32'h5EED_0042);
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (rs_valid !== 1'b0 || rs_fault !== 1'b0) begin
      errors++;
      $display("FAIL R12: got valid %0b fault %0b exp 0 0", rs_valid, rs_fault);
    end
    look(32'h0000_0ABC, 8'h00, 1'b0, "R12 cleared entry invalid");
    look(32'h1234_5678, 8'h00, 1'b0, "R8 miss after reset");

    for (int k = 0; k < 10; k++) begin
      put(0, pat(k), 32'h8000_0000, 8'h11, 1'b0,
          lo_word(24'hABC00 + 24'(k), 1'b1, 1'b1), lo_word(24'h12345, 1'b1, 1'b0));
      look(32'h8000_0000 | (32'h0FFF_FFFF >> (26 - shift_of(pat(k)) + 2)), 8'h11, 1'b0, "R1 R4 even");
      look(32'h8000_0000 | (32'h1 << shift_of(pat(k))) | 32'h3FF, 8'h11, 1'b1, "R3 odd clean write");
      look(32'h8000_0000 | (32'h2 << shift_of(pat(k))), 8'h11, 1'b0, "R2 beyond pair");
    end

    put(3, 27'h1FFF, 32'h2000_4000, 8'h05, 1'b0,
        lo_word(24'h00777, 1'b1, 1'b0), lo_word(24'h00888, 1'b0, 1'b1));
    look(32'h2000_4123, 8'h05, 1'b0, "R6 clean read ro");
    look(32'h2000_4123, 8'h05, 1'b1, "R6 clean write mod");
    look(32'h2000_5123, 8'h05, 1'b0, "R7 invalid read");
    look(32'h2000_5123, 8'h05, 1'b1, "R7 invalid write");
    look(32'h2000_4123, 8'h06, 1'b1, "R8 asid mismatch store");
    look(32'h2000_8000, 8'h05, 1'b0, "R2 neighbour pair miss");
    look_and_put(32'h2000_4010, 8'h05, 1'b1, 3, 27'h1FFF, 32'h2000_4000, 8'h05, 1'b0,
                 lo_word(24'h00999, 1'b1, 1'b1), lo_word(24'h00888, 1'b0, 1'b1));
    look(32'h2000_4010, 8'h05, 1'b1, "R10 R5 write visible next");

    put(5, 27'h1FFF, 32'h4000_0000, 8'h99, 1'b1, lo_word(24'h00111, 1'b1, 1'b1), 32'h0);
    put(9, 27'h1FFF, 32'h4000_0000, 8'h99, 1'b1, lo_word(24'h00222, 1'b1, 1'b1), 32'h0);
    look(32'h4000_0ABC, 8'h01, 1'b0, "R9 lowest index global");

    for (int i = 0; i < N; i++)
      put(i, pat(int'($urandom_range(0, 9))), $urandom, 8'($urandom_range(0, 7)),
          ($urandom_range(0, 7) == 0), $urandom, $urandom);

    for (int n = 0; n < 3000; n++) begin
      int e = int'($urandom_range(0, N - 1));
      logic [31:0] keep = 32'hFFFF_FFFF << (m_sh[e] + 1);
      logic [31:0] va = (m_tag[e] & keep) | ($urandom & ~keep);
      logic [7:0] a = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 7)) : m_asid[e];
      if ($urandom_range(0, 9) == 0) va = $urandom;
      if ($urandom_range(0, 19) == 0)
        look_and_put(va, a, 1'($urandom), int'($urandom_range(0, N - 1)),
                     pat(int'($urandom_range(0, 9))), va, a, 1'($urandom), $urandom, $urandom);
      else
        look(va, a, 1'($urandom), "R5 R6 R7 R8 random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got no finish exp finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule